// File: doc/BRIEF.md
# Input Virtual-Channel Dequeue Controller

This block serves one router input port. It keeps one flit queue per virtual channel (VC) and tracks where each VC's current packet is in its life: idle, waiting for an output VC, or holding one. Flits arrive from the link tagged with the input VC they belong to. A head flit that reaches the front of its queue gives its output port and raises a request for an output VC. When the VC allocator answers, the VC becomes eligible to bid for the switch.

When the switch allocator grants a bidding VC, the controller pops that VC's front flit in the same cycle and presents it to the crossbar input multiplexer. The flit's VC id field is overwritten with the output VC reserved for the packet. A credit naming the freed input VC goes back upstream in the same cycle. If the output-VC answer and the switch grant arrive together, the fresh answer goes into the departing flit. When the last flit of a packet leaves, the VC drops its output port, its output-VC lock and its output VC, and a new packet has to go through VC allocation again.

Top module: `ivc_dequeue_ctrl`

## Requirements
- R1: A flit written with `in_valid` joins the queue of VC `in_vc` and leaves in arrival order. Each queue holds `DEPTH` flits. Writing into a full queue is an error that an assertion reports. Flit kind encoding: bit 0 marks the first flit of a packet and bit 1 marks the last, so 00 = body, 01 = head, 10 = tail, 11 = single-flit packet.
- R2: The cycle after a head or single-flit packet reaches the front of an idle VC, `va_req` for that VC goes high. The VC's output port is taken from the low `PORT_W` bits of that flit's payload.
- R3: A VC allocator answer (`va_valid`, `va_ivc`, `va_ovc`) to a VC that is waiting stores the output VC, and that VC's `va_req` is low in the next cycle. An answer to a VC that is not waiting changes nothing.
- R4: `sw_req` for a VC is high exactly when its queue is non-empty and it either holds an output VC or receives one in the current cycle.
- R5: A `sa_grant` bit on a VC whose `sw_req` is high pops that VC's front flit in the same cycle. `out_valid` is then high and `out_type`, `out_payload` and `out_port` show the flit and its stored port. A grant bit on a VC that is not requesting has no effect.
- R6: The departing flit's `out_vcid` equals the output VC stored for its input VC.
- R7: When the allocator answers a VC in the same cycle in which that VC is granted, `out_vcid` carries the newly answered output VC.
- R8: Each pop raises `credit_valid` in the same cycle, with `credit_vc` naming the input VC that was popped. There is no credit without a pop.
- R9: After a tail flit departs, its VC is idle. It stops requesting the switch, and the next packet must raise `va_req` and be answered again before it can bid.
- R10: A single-flit packet takes the VC from idle through allocation and back to idle. If it is answered and granted in the same cycle, the VC is idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Flit write from the link |
| in_vc | input | VCW | Input VC of the written flit |
| in_type | input | 2 | Flit kind (bit 0 first, bit 1 last) |
| in_payload | input | DATA_W | Flit payload; low PORT_W bits of a head give the output port |
| va_req | output | NUM_VC | Per-VC request for an output VC |
| va_valid | input | 1 | VC allocator answer present |
| va_ivc | input | VCW | Input VC being answered |
| va_ovc | input | VCW | Output VC granted |
| sw_req | output | NUM_VC | Per-VC switch request |
| sa_grant | input | NUM_VC | Switch allocator grant, at most one bit set |
| out_valid | output | 1 | Flit leaving toward the crossbar |
| out_type | output | 2 | Kind of the leaving flit |
| out_vcid | output | VCW | Rewritten VC id of the leaving flit |
| out_port | output | PORT_W | Output port of the leaving flit |
| out_payload | output | DATA_W | Payload of the leaving flit |
| credit_valid | output | 1 | Credit returned upstream |
| credit_vc | output | VCW | Input VC whose slot was freed |

## Verification
The output-VC answer and the switch grant can land on the same VC in the same cycle. In that case the answer must reach the departing flit without passing through the VC's stored state. The random stimulus makes this happen by issuing grants against the model's view of `sw_req`, which already counts an answer arriving in that cycle. A directed single-flit packet forces the overlap once more. The bench judges the cycle by comparing `out_vcid` with the answered VC and by checking that the VC goes idle on the next cycle.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  typedef enum logic [1:0] {
    FK_BODY = 2'b00,
    FK_HEAD = 2'b01,
    FK_TAIL = 2'b10,
    FK_SOLO = 2'b11
  } flit_kind_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_WAITVA = 2'd1,
    PH_ACTIVE = 2'd2
  } vc_phase_t;

  // kind bit 0: first flit of a packet
  function automatic logic opens_packet(input logic [1:0] kind);
    return kind[0];
  endfunction

  // kind bit 1: last flit of a packet
  function automatic logic closes_packet(input logic [1:0] kind);
    return kind[1];
  endfunction

endpackage

// File: rtl/ivc_fifo.sv
module ivc_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CAP);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ivc_vc_state.sv
module ivc_vc_state
  import ivc_pkg::*;
#(
  parameter int VCW    = 2,
  parameter int PORT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_valid,
  input  logic [1:0]        head_kind,
  input  logic [PORT_W-1:0] head_port,
  input  logic              va_hit,
  input  logic [VCW-1:0]    va_ovc,
  input  logic              dequeue,
  output logic              va_req,
  output logic              sw_eligible,
  output logic [PORT_W-1:0] port,
  output logic [VCW-1:0]    ovc_eff
);
  vc_phase_t         phase;
  logic [VCW-1:0]    ovc_q;
  logic [PORT_W-1:0] port_q;
  logic              answered;
  logic              leaving;

  assign answered    = (phase == PH_WAITVA) && va_hit;
  assign leaving     = dequeue && closes_packet(head_kind);
  assign va_req      = (phase == PH_WAITVA);
  assign sw_eligible = head_valid && ((phase == PH_ACTIVE) || answered);
  assign ovc_eff     = answered ? va_ovc : ovc_q;
  assign port        = port_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      ovc_q  <= '0;
      port_q <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (head_valid && opens_packet(head_kind)) begin
            phase  <= PH_WAITVA;
            port_q <= head_port;
          end
        end
        PH_WAITVA: begin
          if (va_hit) begin
            if (leaving) begin
              phase  <= PH_IDLE;
              ovc_q  <= '0;
              port_q <= '0;
            end else begin
              phase <= PH_ACTIVE;
              ovc_q <= va_ovc;
            end
          end
        end
        PH_ACTIVE: begin
          if (leaving) begin
            phase  <= PH_IDLE;
            ovc_q  <= '0;
            port_q <= '0;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ivc_dequeue_ctrl.sv
module ivc_dequeue_ctrl
  import ivc_pkg::*;
#(
  parameter int NUM_VC = 4,
  parameter int DEPTH  = 4,
  parameter int DATA_W = 16,
  parameter int PORT_W = 3,
  localparam int VCW   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [VCW-1:0]    in_vc,
  input  logic [1:0]        in_type,
  input  logic [DATA_W-1:0] in_payload,
  output logic [NUM_VC-1:0] va_req,
  input  logic              va_valid,
  input  logic [VCW-1:0]    va_ivc,
  input  logic [VCW-1:0]    va_ovc,
  output logic [NUM_VC-1:0] sw_req,
  input  logic [NUM_VC-1:0] sa_grant,
  output logic              out_valid,
  output logic [1:0]        out_type,
  output logic [VCW-1:0]    out_vcid,
  output logic [PORT_W-1:0] out_port,
  output logic [DATA_W-1:0] out_payload,
  output logic              credit_valid,
  output logic [VCW-1:0]    credit_vc
);
  localparam int FW = 2 + DATA_W;

  logic [FW-1:0]     head_flit [NUM_VC];
  logic [PORT_W-1:0] port_v    [NUM_VC];
  logic [VCW-1:0]    ovc_v     [NUM_VC];
  logic [NUM_VC-1:0] fifo_empty, fifo_full, deq_oh;

  // named internal events for the checker
  logic           deq_fire;
  logic [VCW-1:0] deq_vc;
  logic           tail_leave;

  for (genvar g = 0; g < NUM_VC; g++) begin : g_vc
    logic push_here;
    logic va_hit_here;
    assign push_here   = in_valid && (in_vc == VCW'(g));
    assign va_hit_here = va_valid && (va_ivc == VCW'(g));

    ivc_fifo #(.W(FW), .DEPTH(DEPTH)) fifo_i (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_here),
      .din   ({in_type, in_payload}),
      .pop   (deq_oh[g]),
      .dout  (head_flit[g]),
      .empty (fifo_empty[g]),
      .full  (fifo_full[g])
    );

    ivc_vc_state #(.VCW(VCW), .PORT_W(PORT_W)) state_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .head_valid  (!fifo_empty[g]),
      .head_kind   (head_flit[g][FW-1 -: 2]),
      .head_port   (head_flit[g][PORT_W-1:0]),
      .va_hit      (va_hit_here),
      .va_ovc      (va_ovc),
      .dequeue     (deq_oh[g]),
      .va_req      (va_req[g]),
      .sw_eligible (sw_req[g]),
      .port        (port_v[g]),
      .ovc_eff     (ovc_v[g])
    );
  end

  // grant filter: lowest granted VC that is actually requesting
  always_comb begin
    deq_fire = 1'b0;
    deq_vc   = '0;
    deq_oh   = '0;
    for (int v = 0; v < NUM_VC; v++) begin
      if (!deq_fire && sa_grant[v] && sw_req[v]) begin
        deq_fire  = 1'b1;
        deq_vc    = VCW'(v);
        deq_oh[v] = 1'b1;
      end
    end
  end

  // crossbar-side multiplexer with VC id rewrite
  always_comb begin
    out_valid   = deq_fire;
    out_type    = deq_fire ? head_flit[deq_vc][FW-1 -: 2] : 2'b00;
    out_payload = deq_fire ? head_flit[deq_vc][DATA_W-1:0] : '0;
    out_vcid    = deq_fire ? ovc_v[deq_vc] : '0;
    out_port    = deq_fire ? port_v[deq_vc] : '0;
  end

  assign tail_leave   = deq_fire && closes_packet(out_type);
  assign credit_valid = deq_fire;
  assign credit_vc    = deq_vc;

endmodule

// File: rtl/ivc_dequeue_chk.sv
module ivc_dequeue_chk #(
  parameter int NUM_VC = 4,
  parameter int VCW    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [VCW-1:0]    in_vc,
  input logic [NUM_VC-1:0] fifo_full,
  input logic              va_valid,
  input logic [VCW-1:0]    va_ivc,
  input logic [VCW-1:0]    va_ovc,
  input logic [NUM_VC-1:0] va_req,
  input logic [NUM_VC-1:0] sw_req,
  input logic [NUM_VC-1:0] sa_grant,
  input logic              out_valid,
  input logic [VCW-1:0]    out_vcid,
  input logic              credit_valid,
  input logic [VCW-1:0]    credit_vc,
  input logic              deq_fire,
  input logic [VCW-1:0]    deq_vc,
  input logic              tail_leave
);
  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !fifo_full[in_vc]);

  // R5
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sa_grant));

  // R8
  credit_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    credit_valid |-> (sw_req[credit_vc] && sa_grant[credit_vc] && out_valid));

  // R3
  va_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (va_valid && va_req[va_ivc]) |=> !va_req[$past(va_ivc)]);

  // R7
  bypass_ovc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && va_valid && va_req[va_ivc] && va_ivc == credit_vc)
      |-> (out_vcid == va_ovc));

  // R9
  tail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tail_leave |=> (!va_req[$past(deq_vc)] && !sw_req[$past(deq_vc)]));

  // R5
  fire_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deq_fire |-> sw_req[deq_vc]);
endmodule

bind ivc_dequeue_ctrl ivc_dequeue_chk #(.NUM_VC(NUM_VC), .VCW(VCW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_vc        (in_vc),
  .fifo_full    (fifo_full),
  .va_valid     (va_valid),
  .va_ivc       (va_ivc),
  .va_ovc       (va_ovc),
  .va_req       (va_req),
  .sw_req       (sw_req),
  .sa_grant     (sa_grant),
  .out_valid    (out_valid),
  .out_vcid     (out_vcid),
  .credit_valid (credit_valid),
  .credit_vc    (credit_vc),
  .deq_fire     (deq_fire),
  .deq_vc       (deq_vc),
  .tail_leave   (tail_leave)
);

// File: tb/ivc_dequeue_ctrl_tb.sv
`timescale 1ns/1ps
module ivc_dequeue_ctrl_tb_top;
  localparam int NUM_VC = 4;
  localparam int DEPTH  = 4;
  localparam int DATA_W = 16;
  localparam int PORT_W = 3;
  localparam int VCW    = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [VCW-1:0]    in_vc = '0;
  logic [1:0]        in_type = '0;
  logic [DATA_W-1:0] in_payload = '0;
  logic [NUM_VC-1:0] va_req;
  logic              va_valid = 1'b0;
  logic [VCW-1:0]    va_ivc = '0;
  logic [VCW-1:0]    va_ovc = '0;
  logic [NUM_VC-1:0] sw_req;
  logic [NUM_VC-1:0] sa_grant = '0;
  logic              out_valid;
  logic [1:0]        out_type;
  logic [VCW-1:0]    out_vcid;
  logic [PORT_W-1:0] out_port;
  logic [DATA_W-1:0] out_payload;
  logic              credit_valid;
  logic [VCW-1:0]    credit_vc;

  always #10 clk = ~clk;

  ivc_dequeue_ctrl #(.NUM_VC(NUM_VC), .DEPTH(DEPTH), .DATA_W(DATA_W), .PORT_W(PORT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc), .in_type(in_type),
    .in_payload(in_payload), .va_req(va_req), .va_valid(va_valid), .va_ivc(va_ivc),
    .va_ovc(va_ovc), .sw_req(sw_req), .sa_grant(sa_grant), .out_valid(out_valid),
    .out_type(out_type), .out_vcid(out_vcid), .out_port(out_port),
    .out_payload(out_payload), .credit_valid(credit_valid), .credit_vc(credit_vc)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // reference model state
  logic [1:0]        m_kind [NUM_VC][DEPTH];
  logic [DATA_W-1:0] m_pay  [NUM_VC][DEPTH];
  int                m_cnt  [NUM_VC];
  int                m_ph   [NUM_VC];   // 0 idle, 1 waiting, 2 holding ovc
  logic [PORT_W-1:0] m_port [NUM_VC];
  logic [VCW-1:0]    m_ovc  [NUM_VC];
  int                g_rem  [NUM_VC];   // -1: next flit opens a packet

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_sw(input int v, input logic vv, input logic [VCW-1:0] vi);
    return (m_cnt[v] > 0) && (m_ph[v] == 2 || (m_ph[v] == 1 && vv && int'(vi) == v));
  endfunction

  task automatic step(input logic en, input logic [VCW-1:0] ev, input logic [1:0] ek,
                      input logic [DATA_W-1:0] ep, input logic vv, input logic [VCW-1:0] vi,
                      input logic [VCW-1:0] vo, input logic [NUM_VC-1:0] gnt);
    logic [NUM_VC-1:0] esw, eva;
    int  dv;
    logic fire;
    @(negedge clk);
    in_valid = en; in_vc = ev; in_type = ek; in_payload = ep;
    va_valid = vv; va_ivc = vi; va_ovc = vo; sa_grant = gnt;
    #1;
    fire = 1'b0; dv = 0;
    for (int v = 0; v < NUM_VC; v++) begin
      esw[v] = exp_sw(v, vv, vi);
      eva[v] = (m_ph[v] == 1);
      if (!fire && gnt[v] && esw[v]) begin fire = 1'b1; dv = v; end
    end
    check("R2 R3 R9 va_req", int'(va_req), int'(eva));
    check("R4 R9 sw_req", int'(sw_req), int'(esw));
    check("R5 out_valid", int'(out_valid), int'(fire));
    check("R8 credit_valid", int'(credit_valid), int'(fire));
    if (fire) begin
      check("R1 R5 out_type", int'(out_type), int'(m_kind[dv][0]));
      check("R1 R5 out_payload", int'(out_payload), int'(m_pay[dv][0]));
      check("R2 R5 out_port", int'(out_port), int'(m_port[dv]));
      check("R6 R7 out_vcid", int'(out_vcid),
            (m_ph[dv] == 1) ? int'(vo) : int'(m_ovc[dv]));
      check("R8 credit_vc", int'(credit_vc), dv);
    end
    @(posedge clk);
    for (int v = 0; v < NUM_VC; v++) begin
      logic deq, hit;
      deq = fire && dv == v;
      hit = vv && int'(vi) == v;
      case (m_ph[v])
        0: if (m_cnt[v] > 0 && m_kind[v][0][0]) begin
             m_ph[v] = 1; m_port[v] = m_pay[v][0][PORT_W-1:0];
           end
        1: if (hit) begin
             if (deq && m_kind[v][0][1]) begin m_ph[v] = 0; m_ovc[v] = '0; m_port[v] = '0; end
             else begin m_ph[v] = 2; m_ovc[v] = vo; end
           end
        default: if (deq && m_kind[v][0][1]) begin
             m_ph[v] = 0; m_ovc[v] = '0; m_port[v] = '0;
           end
      endcase
      if (deq) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          m_kind[v][i] = m_kind[v][i+1]; m_pay[v][i] = m_pay[v][i+1];
        end
        m_cnt[v]--;
      end
      if (en && int'(ev) == v && m_cnt[v] < DEPTH) begin
        m_kind[v][m_cnt[v]] = ek; m_pay[v][m_cnt[v]] = ep; m_cnt[v]++;
      end
    end
  endtask

  function automatic logic [1:0] gen_kind(input int v);
    logic [1:0] k;
    if (g_rem[v] < 0) begin
      if ($urandom % 4 == 0) k = 2'b11;
      else begin k = 2'b01; g_rem[v] = int'($urandom % 3); end
    end else if (g_rem[v] > 0) begin
      k = 2'b00; g_rem[v]--;
    end else begin
      k = 2'b10; g_rem[v] = -1;
    end
    return k;
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int v = 0; v < NUM_VC; v++) begin
      m_cnt[v] = 0; m_ph[v] = 0; m_port[v] = '0; m_ovc[v] = '0; g_rem[v] = -1;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // reset state
    check("R2 reset va_req", int'(va_req), 0);
    check("R4 reset sw_req", int'(sw_req), 0);
    check("R5 reset out_valid", int'(out_valid), 0);
    check("R8 reset credit_valid", int'(credit_valid), 0);

    // R10 / R7: single-flit packet answered and granted in the same cycle
    step(1'b1, 2'd2, 2'b11, 16'h00A3, 1'b0, 2'd0, 2'd0, 4'b0000);
    step(1'b0, 2'd0, 2'b00, 16'h0000, 1'b0, 2'd0, 2'd0, 4'b0000);
    step(1'b0, 2'd0, 2'b00, 16'h0000, 1'b1, 2'd2, 2'd1, 4'b0100);
    step(1'b0, 2'd0, 2'b00, 16'h0000, 1'b0, 2'd0, 2'd0, 4'b0000);

    // R6 / R9: stored output VC used across a three-flit packet, then cleared
    step(1'b1, 2'd1, 2'b01, 16'h1235, 1'b0, 2'd0, 2'd0, 4'b0000);
    step(1'b1, 2'd1, 2'b00, 16'hBEEF, 1'b0, 2'd0, 2'd0, 4'b0000);
    step(1'b1, 2'd1, 2'b10, 16'hCAFE, 1'b1, 2'd0, 2'd2, 4'b0010); // R3 ignored answer, R5 ignored grant
    step(1'b0, 2'd0, 2'b00, 16'h0000, 1'b1, 2'd1, 2'd3, 4'b0000);
    step(1'b0, 2'd0, 2'b00, 16'h0000, 1'b0, 2'd0, 2'd0, 4'b0010);
    step(1'b0, 2'd0, 2'b00, 16'h0000, 1'b1, 2'd1, 2'd0, 4'b0010); // R3 late answer ignored
    step(1'b0, 2'd0, 2'b00, 16'h0000, 1'b0, 2'd0, 2'd0, 4'b0010);
    step(1'b0, 2'd0, 2'b00, 16'h0000, 1'b0, 2'd0, 2'd0, 4'b0010);

    // constrained random traffic
    for (int cyc = 0; cyc < 4000; cyc++) begin
      logic en, vv;
      logic [VCW-1:0] ev, vi, vo;
      logic [1:0] ek;
      logic [DATA_W-1:0] ep;
      logic [NUM_VC-1:0] gnt;
      int gv, r;
      ev = VCW'($urandom % NUM_VC);
      en = ($urandom % 10 < 6) && (m_cnt[ev] < DEPTH);
      ek = 2'b00;
      if (en) ek = gen_kind(int'(ev));
      ep = DATA_W'($urandom);
      vv = ($urandom % 10 < 4);
      vi = VCW'($urandom % NUM_VC);
      vo = VCW'($urandom % NUM_VC);
      gnt = '0;
      gv = int'($urandom % NUM_VC);
      r  = int'($urandom % 10);
      if (r < 7 && exp_sw(gv, vv, vi)) gnt[gv] = 1'b1;
      else if (r == 9) gnt[gv] = 1'b1;
      step(en, ev, ek, ep, vv, vi, vo, gnt);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule